// File: doc/BRIEF.md
# Triggered Latency-Delayed Capture Controller

This block performs one triggered acquisition of a multi-channel sample stream. Each sample word packs eight 12-bit channels into 96 bits and arrives once per cycle of a 40 MHz clock. A host arms the block by writing a start bit. The block then waits for a trigger, lets a programmable number of clock ticks pass, and stores a run of consecutive sample words in an internal dual-port spy buffer.

When the buffer is full the block raises an end-of-acquisition flag. The host polls this flag in the status register. After the flag is high, the host reads the captured words back one byte at a time through a data register that moves its own read pointer forward. Writing the start bit again clears the flag and both pointers, so a new acquisition can begin.

The host port is a byte-wide register port with four addresses. All reads return their byte one cycle after the read strobe.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset, the status register (address 0) reads 0x00. The latency register reads 1: address 1 holds the low 8 bits and address 2 holds the upper 4 bits in bits 3:0.
- R2: Writing address 0 with bit 0 set arms the block. While the block waits for a trigger, status bit 0 reads 1. A trigger that arrives before the block is armed, or after a capture has finished, has no effect.
- R3: Let the trigger be sampled at clock edge t and let L be the latency register value. The first stored word is the sample present at edge t+L. A value of 0 is treated as 1. The full range 1 to 4095 is accepted.
- R4: Exactly DEPTH consecutive sample words are stored, starting with the first one. Capture then stops.
- R5: Status bit 0 (armed) clears once a trigger is accepted. Status bit 1 (busy) reads 1 during the latency wait and during recording.
- R6: When the last word has been written, status bit 7 (done) becomes 1 and busy returns to 0.
- R7: Triggers that arrive during the latency wait or during recording are ignored. The stored data stays aligned to the first trigger.
- R8: Each read of address 3 returns one byte of the buffer and advances the read pointer. Within a word, byte b is bits [8b+7:8b], from b=0 up to b=11. After byte 11 the pointer moves to the next word. Channel k of a word sits at bits [12k+11:12k].
- R9: Writing the start bit again clears done and resets the write and read pointers to word 0, byte 0.
- R10: Every register read returns its data in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sample and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | 96 | Eight packed 12-bit channels, sampled every cycle |
| trig_in | input | 1 | Trigger strobe, sampled every cycle |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address: 0 status/control, 1 latency low, 2 latency high, 3 data |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, valid one cycle after the read strobe |

## Verification
The assertions assume that the sample and trigger inputs, and the host strobes, are synchronous to the clock. They also assume that the host writes registers and reads data only through single-cycle strobes. The bench drives every input just after the falling edge. It changes the latency registers only while no capture is in progress. It reads the data register only after done is observed. This keeps the reading of sample-to-edge alignment unambiguous.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_WAIT  = 2'd2,
      ST_REC   = 2'd3
   } cap_state_t;

   localparam logic [1:0] A_CTRL  = 2'd0;
   localparam logic [1:0] A_LAT_L = 2'd1;
   localparam logic [1:0] A_LAT_H = 2'd2;
   localparam logic [1:0] A_DATA  = 2'd3;
endpackage

// File: rtl/cap_sequencer.sv
module cap_sequencer
   import tcap_pkg::*;
#(
   parameter int LAT_W = 12,
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             trig,
   input  logic [LAT_W-1:0] lat,
   output cap_state_t       state,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic             done
);
   logic [LAT_W-1:0] cnt;
   logic [AW-1:0]    wptr;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("cap_sequencer: DEPTH must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         wptr  <= '0;
         done  <= 1'b0;
      end else if (start) begin
         state <= ST_ARMED;
         done  <= 1'b0;
         wptr  <= '0;
      end else begin
         case (state)
            ST_ARMED: if (trig) begin
               if (lat <= LAT_W'(1)) state <= ST_REC;
               else begin
                  state <= ST_WAIT;
                  cnt   <= lat - LAT_W'(1);
               end
            end
            ST_WAIT: begin
               if (cnt == LAT_W'(1)) state <= ST_REC;
               else cnt <= cnt - LAT_W'(1);
            end
            ST_REC: begin
               wptr <= wptr + AW'(1);
               if (wptr == AW'(DEPTH - 1)) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign wr_en   = (state == ST_REC);
   assign wr_addr = wptr;

   // R4 / R6: last word ends recording and raises done
   p_last_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REC && wptr == AW'(DEPTH - 1) && !start) |=> (done && state == ST_IDLE));
   // R7: trigger during wait does not reload the count
   p_wait_ignores_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && cnt != LAT_W'(1) && !start) |=> (state == ST_WAIT && cnt == $past(cnt) - LAT_W'(1)));
   // R3: latency of one or zero enters recording on the next edge
   p_short_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED && trig && lat <= LAT_W'(1) && !start) |=> (state == ST_REC && wptr == '0));
   // R9: restart clears done and the write pointer
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && state == ST_ARMED && wptr == '0));
   // R6: done only while idle
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> state == ST_IDLE);
endmodule

// File: rtl/spy_buffer.sv
module spy_buffer #(
   parameter int W     = 96,
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/byte_port.sv
module byte_port #(
   parameter int W     = 96,
   parameter int DEPTH = 512,
   localparam int AW = $clog2(DEPTH),
   localparam int NB = W / 8,
   localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          adv,
   input  logic [W-1:0]  word_in,
   output logic [AW-1:0] raddr,
   output logic [7:0]    byte_out
);
   logic [BW-1:0] bsel;
   logic [7:0]    bytes [NB];

   if (W % 8 != 0) begin : g_bad_width
      $error("byte_port: word width must be a whole number of bytes");
   end

   for (genvar b = 0; b < NB; b++) begin : g_split
      assign bytes[b] = word_in[8*b +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         bsel  <= '0;
         raddr <= '0;
      end else if (adv) begin
         if (bsel == BW'(NB - 1)) begin
            bsel  <= '0;
            raddr <= raddr + AW'(1);
         end else begin
            bsel <= bsel + BW'(1);
         end
      end
   end

   assign byte_out = bytes[bsel];

   // R8: byte index stays within a word
   p_bsel_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bsel <= BW'(NB - 1));
   // R8: word pointer moves only after the last byte
   p_word_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clear && bsel != BW'(NB - 1)) |=> $stable(raddr));
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
   import tcap_pkg::*;
#(
   parameter int CH_W  = 12,
   parameter int N_CH  = 8,
   parameter int DEPTH = 512,
   parameter int LAT_W = 12,
   localparam int W  = CH_W * N_CH,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample_in,
   input  logic         trig_in,
   input  logic         host_wr_en,
   input  logic         host_rd_en,
   input  logic [1:0]   host_addr,
   input  logic [7:0]   host_wdata,
   output logic [7:0]   host_rdata
);
   cap_state_t       state;
   logic             wr_en, done, start;
   logic [AW-1:0]    wr_addr, rd_addr;
   logic [W-1:0]     rd_word;
   logic [7:0]       data_byte, status;
   logic [LAT_W-1:0] lat;
   logic [15:0]      lat_ext;
   logic             data_rd;

   if (LAT_W <= 8 || LAT_W > 16) begin : g_bad_lat
      $error("trig_capture_ctrl: LAT_W must lie in 9..16");
   end

   assign start   = host_wr_en && host_addr == A_CTRL && host_wdata[0];
   assign data_rd = host_rd_en && host_addr == A_DATA;
   assign lat_ext = 16'(lat);
   assign status  = {done, 5'b0, (state == ST_WAIT || state == ST_REC), (state == ST_ARMED)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat <= LAT_W'(1);
      end else if (host_wr_en) begin
         if (host_addr == A_LAT_L) lat[7:0] <= host_wdata;
         if (host_addr == A_LAT_H) lat[LAT_W-1:8] <= host_wdata[LAT_W-9:0];
      end
   end

   cap_sequencer #(.LAT_W(LAT_W), .DEPTH(DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .trig(trig_in), .lat(lat),
      .state(state), .wr_en(wr_en), .wr_addr(wr_addr), .done(done)
   );

   spy_buffer #(.W(W), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(sample_in),
      .raddr(rd_addr), .rdata(rd_word)
   );

   byte_port #(.W(W), .DEPTH(DEPTH)) u_rd (
      .clk(clk), .rst_n(rst_n), .clear(start), .adv(data_rd),
      .word_in(rd_word), .raddr(rd_addr), .byte_out(data_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_rd_en) begin
         case (host_addr)
            A_CTRL:  host_rdata <= status;
            A_LAT_L: host_rdata <= lat_ext[7:0];
            A_LAT_H: host_rdata <= lat_ext[15:8];
            default: host_rdata <= data_byte;
         endcase
      end
   end

   // R10: a status read shows the previous cycle's status
   p_status_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && host_addr == A_CTRL) |=> host_rdata == $past(status));
   // R5: armed and busy are never both set
   p_arm_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[0] && status[1]));
endmodule

// File: tb/tb_trig_capture_ctrl.sv
module tb_trig_capture_ctrl;
   localparam int CLK_NS = 25;
   localparam int DEPTH  = 16;
   localparam int W      = 96;
   localparam int NB     = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] sample_in = '0;
   logic         trig_in = 1'b0;
   logic         host_wr_en = 1'b0, host_rd_en = 1'b0;
   logic [1:0]   host_addr = '0;
   logic [7:0]   host_wdata = '0;
   logic [7:0]   host_rdata;

   int checks = 0, errors = 0, smp_idx = 0;
   bit finished = 0;

   trig_capture_ctrl #(.DEPTH(DEPTH)) dut (.*);

   always #(CLK_NS / 2.0) clk = ~clk;

   function automatic logic [W-1:0] mk(int n);
      logic [W-1:0] v;
      for (int k = 0; k < 8; k++) v[12*k +: 12] = 12'((n * 37 + k * 273 + 5) & 12'hFFF);
      return v;
   endfunction

   always @(negedge clk) begin
      smp_idx   <= smp_idx + 1;
      sample_in <= mk(smp_idx + 1);
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk); #1;
      host_addr = a; host_wdata = d; host_wr_en = 1'b1;
      @(negedge clk); #1;
      host_wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk); #1;
      host_addr = a; host_rd_en = 1'b1;
      @(negedge clk); #1;
      host_rd_en = 1'b0;
      d = host_rdata;
   endtask

   // returns the sample index present at the trigger edge
   task automatic pulse_trig(output int idx);
      @(negedge clk); #1;
      idx = smp_idx;
      trig_in = 1'b1;
      @(negedge clk); #1;
      trig_in = 1'b0;
   endtask

   task automatic run(int lat);
      logic [7:0] d;
      int t0, eff, polls, junk;
      logic [W-1:0] exp_w;
      eff = (lat == 0) ? 1 : lat;
      wr(2'd1, 8'(lat & 255));
      wr(2'd2, 8'(lat >> 8));
      rd(2'd1, d); chk("R3 lat low readback", d, lat & 255);
      rd(2'd2, d); chk("R3 lat high readback", d, lat >> 8);
      wr(2'd0, 8'h01);
      rd(2'd0, d); chk("R2 R9 armed, done cleared", d, 8'h01);
      pulse_trig(t0);
      // extra trigger during wait or record (R7)
      pulse_trig(junk);
      rd(2'd0, d);
      if (eff + 1 < DEPTH) chk("R5 busy after trigger", d, 8'h02);
      polls = 0;
      do begin rd(2'd0, d); polls++; end while (d[7] == 1'b0 && polls < 6000);
      chk("R6 done, busy cleared", d, 8'h80);
      pulse_trig(junk);
      rd(2'd0, d); chk("R2 trigger after done ignored", d, 8'h80);
      for (int j = 0; j < DEPTH; j++) begin
         exp_w = mk(t0 + eff + j);
         for (int b = 0; b < NB; b++) begin
            rd(2'd3, d);
            chk($sformatf("R3 R4 R7 R8 word %0d byte %0d lat %0d", j, b, lat), d, exp_w[8*b +: 8]);
         end
      end
   endtask

   initial begin
      logic [7:0] d;
      int junk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(2'd0, d); chk("R1 status reset", d, 8'h00);
      rd(2'd1, d); chk("R1 lat low reset", d, 8'h01);
      rd(2'd2, d); chk("R1 lat high reset", d, 8'h00);
      pulse_trig(junk);
      rd(2'd0, d); chk("R2 trigger while unarmed ignored", d, 8'h00);
      run(1);
      run(0);
      run(2);
      run(3);
      run(13);
      run(4095);
      // R9 restart mid-wait resets pointers and flag
      wr(2'd1, 8'd200); wr(2'd2, 8'd0);
      wr(2'd0, 8'h01);
      pulse_trig(junk);
      wr(2'd0, 8'h01);
      rd(2'd0, d); chk("R9 restart returns to armed", d, 8'h01);
      run(5);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule